// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a memory-mapped timer that produces a steady heartbeat for system software. A fixed divide-by-16 prescaler turns the system clock into a slow tick. On each tick an interval counter moves one step toward a programmed limit. When the counter reaches the limit it wraps back to zero. Each wrap completes one period: it sets a sticky event flag and adds one to a 12-bit tally of periods completed since the last acknowledge. A level interrupt is asserted while the flag is set and interrupts are enabled.

Software configures the timer through a four-word register window. The mode word holds the interval, the run enable and the interrupt enable. A status word shows the flag. Two count words return the live count together with the period tally:
- the acknowledging word clears the flag and the tally as a side effect of being read;
- the snapshot word leaves all state untouched.

A tick handler can therefore tell how many periods it missed. A free-running time base can be built from the tally and the live count.

The counter is controlled by a three-state machine:
- **ST_IDLE** holds the count at zero. It moves to ST_RUN on a tick that finds the run enable set.
- **ST_RUN** counts on every tick. On a tick that finds the enable cleared, it moves to ST_DRAIN, or straight to ST_IDLE if that tick is also a wrap.
- **ST_DRAIN** keeps counting to the end of the current period. It moves to ST_IDLE at the wrap, or back to ST_RUN at the wrap if the enable has been set again, or back to ST_RUN on any tick that sees the enable set again.

The interval limit is reloaded from the mode word on entry to ST_RUN from ST_IDLE and at every wrap.

Top module: `ivt_timer`

## Requirements
- R1: After reset, the following all read zero: the mode word (offset 0x0), the status word (0x4), the acknowledging count word (0x8) and the snapshot count word (0xC). `irq` is low.
- R2: Only the mode word is writable. Its fields are:
  - bits 19:0: interval value;
  - bit 24: run enable;
  - bit 25: interrupt enable.
  All other mode bits read zero. Writes to 0x4, 0x8 or 0xC change nothing. Reads of unaligned offsets return zero.
- R3: With run enable set and interval value v, successive period completions are exactly (v+1)*16 clock cycles apart.
- R4: Every period completion adds one to the tally. Both count words return the live count in bits 19:0 and the tally in bits 31:20.
- R5: A read of offset 0x8 returns the count and tally held before the read. After that clock edge, the status flag (status bit 0) and the tally are zero.
- R6: Reads of offset 0x4 or 0xC never change the flag, the tally or the count.
- R7: `irq` is high exactly while status bit 0 and mode bit 25 are both set. A change to bit 25 shows on `irq` in the cycle after the write.
- R8: The tally stops at 4095 and stays there until acknowledged.
- R9: Clearing run enable lets the count run on to the programmed limit. That final wrap sets the flag. The count then holds at zero.
- R10: A new interval value written while running does not affect the period in progress. It governs every period after the next wrap.
- R11: An acknowledging read in the same cycle as a wrap returns the pre-wrap count. Afterwards the flag is set, the tally is 1 and the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset into the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq | output | 1 | Level interrupt request |

## Verification
Two things can fall in the same clock edge: the acknowledge produced by reading offset 0x8, and a period wrap. Their handling decides whether an event is lost. The bench finds the tick phase by snapshot-polling the count until it changes to the limit value. It then places the acknowledging read exactly sixteen cycles later, on the wrap edge. The read is judged correct when it returns the pre-wrap count and a snapshot taken right after shows count 0, tally 1 and the flag still set. A snapshot still showing the old count would prove the read landed a cycle early.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } ivt_state_t;

    // register window offsets (bytes)
    localparam int OFS_MODE  = 0;
    localparam int OFS_FLAG  = 4;
    localparam int OFS_VALUE = 8;
    localparam int OFS_IMAGE = 12;

    // control bit positions in the mode word
    localparam int MODE_EN_BIT  = 24;
    localparam int MODE_IEN_BIT = 25;
endpackage

// File: rtl/ivt_prescale.sv
module ivt_prescale #(
    parameter int PRE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    assign tick = &pre_q;

    // ticks are isolated single-cycle pulses
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/ivt_core.sv
module ivt_core
    import ivt_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int TALLY_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               run_req,
    input  logic [CNT_W-1:0]   ival,
    input  logic               ack,
    output logic [CNT_W-1:0]   count,
    output logic [TALLY_W-1:0] tally,
    output logic               flag
);
    localparam logic [TALLY_W-1:0] TALLY_MAX = '1;
    localparam logic [TALLY_W-1:0] TALLY_ONE = TALLY_W'(1);

    ivt_state_t       state, state_nx;
    logic [CNT_W-1:0] limit, limit_nx, count_nx;
    logic             wrap;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state and counter steering
    always_comb begin
        state_nx = state;
        count_nx = count;
        limit_nx = limit;
        wrap     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (tick && run_req) begin
                    state_nx = ST_RUN;
                    limit_nx = ival;
                end
            end
            ST_RUN, ST_DRAIN: begin
                if (tick) begin
                    if (count == limit) begin
                        wrap     = 1'b1;
                        count_nx = '0;
                        limit_nx = ival;
                        state_nx = run_req ? ST_RUN : ST_IDLE;
                    end else begin
                        count_nx = count + 1'b1;
                        state_nx = run_req ? ST_RUN : ST_DRAIN;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath and event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            limit <= '0;
            flag  <= 1'b0;
            tally <= '0;
        end else begin
            count <= count_nx;
            limit <= limit_nx;
            if (wrap) begin
                flag  <= 1'b1;
                tally <= ack ? TALLY_ONE
                       : (tally == TALLY_MAX) ? TALLY_MAX : tally + 1'b1;
            end else if (ack) begin
                flag  <= 1'b0;
                tally <= '0;
            end
        end
    end

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (count == '0));
    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= limit);
    assert_tally_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tally == TALLY_MAX && !ack) |=> (tally == TALLY_MAX));
    assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wrap) |=> (!flag && tally == '0));
    assert_ack_on_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && wrap) |=> (flag && tally == TALLY_ONE && count == '0));
endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 20,
    parameter int TALLY_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]   count,
    input  logic [TALLY_W-1:0] tally,
    input  logic               flag,
    output logic [CNT_W-1:0]   ival,
    output logic               run_req,
    output logic               irq_en,
    output logic               ack
);
    logic wr_mode, rd_any;
    logic unused_wbits;

    assign wr_mode = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_MODE));
    assign rd_any  = bus_sel && !bus_wr;
    assign ack     = rd_any && (bus_addr == ADDR_W'(OFS_VALUE));
    assign unused_wbits = ^{bus_wdata[DATA_W-1:MODE_IEN_BIT+1],
                            bus_wdata[MODE_EN_BIT-1:CNT_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ival    <= '0;
            run_req <= 1'b0;
            irq_en  <= 1'b0;
        end else if (wr_mode) begin
            ival    <= bus_wdata[CNT_W-1:0];
            run_req <= bus_wdata[MODE_EN_BIT];
            irq_en  <= bus_wdata[MODE_IEN_BIT];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_any) begin
            if (bus_addr == ADDR_W'(OFS_MODE)) begin
                bus_rdata[CNT_W-1:0]    = ival;
                bus_rdata[MODE_EN_BIT]  = run_req;
                bus_rdata[MODE_IEN_BIT] = irq_en;
            end else if (bus_addr == ADDR_W'(OFS_FLAG)) begin
                bus_rdata[0] = flag;
            end else if (bus_addr == ADDR_W'(OFS_VALUE) ||
                         bus_addr == ADDR_W'(OFS_IMAGE)) begin
                bus_rdata = DATA_W'({tally, count});
            end
        end
    end

    assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> (ival == $past(bus_wdata[CNT_W-1:0]) &&
                     run_req == $past(bus_wdata[MODE_EN_BIT]) &&
                     irq_en == $past(bus_wdata[MODE_IEN_BIT])));
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer #(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 20,
    parameter int TALLY_W = 12,
    parameter int PRE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic               tick, run_req, irq_en, ack, flag;
    logic [CNT_W-1:0]   ival, count;
    logic [TALLY_W-1:0] tally;

    ivt_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    ivt_core #(.CNT_W(CNT_W), .TALLY_W(TALLY_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run_req(run_req),
        .ival(ival), .ack(ack), .count(count), .tally(tally), .flag(flag)
    );

    ivt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
               .TALLY_W(TALLY_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count), .tally(tally), .flag(flag), .ival(ival),
        .run_req(run_req), .irq_en(irq_en), .ack(ack)
    );

    assign irq = flag & irq_en;
endmodule

// File: tb/sim_ivt_timer.sv
module sim_ivt_timer;
    localparam int CLK_P = 10;

    logic        clk = 1'b0, rst_n = 1'b0, sel = 1'b0, wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int errors = 0, checks = 0, cyc = 0;
    bit done = 0;

    ivt_timer u0 (.clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr),
                  .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
                  .irq(irq));

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(posedge clk); #1 sel = 1'b0;
    endtask

    task automatic wrr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1 sel = 1'b0; wr = 1'b0;
    endtask

    task automatic wait_flag(output int at);
        logic [31:0] d;
        d = '0;
        for (int n = 0; n < 5000; n++) begin
            rd(4'h4, d);
            if (d[0]) break;
        end
        if (!d[0]) check("R3 flag never rose", 0, 1);
        at = cyc;
    endtask

    // leave count 0 if there, then track the maximum until count returns to 0
    task automatic run_max(output int mx);
        logic [31:0] d;
        mx = 0;
        for (int n = 0; n < 2000; n++) begin
            rd(4'hC, d);
            if (d[19:0] != 0) break;
        end
        for (int n = 0; n < 4000; n++) begin
            if (int'(d[19:0]) > mx) mx = int'(d[19:0]);
            rd(4'hC, d);
            if (d[19:0] == 0) break;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 irq", {31'b0, irq}, 0);
        rd(4'h0, d); check("R1 mode", d, 0);
        rd(4'h4, d); check("R1 status", d, 0);
        rd(4'hC, d); check("R1 image", d, 0);
        rd(4'h8, d); check("R1 value", d, 0);
        wrr(4'h4, 32'hFFFF_FFFF); wrr(4'hC, 32'hFFFF_FFFF);
        rd(4'h4, d); check("R2 status ignores write", d, 0);
        rd(4'hC, d); check("R2 image ignores write", d, 0);
        rd(4'h2, d); check("R2 unaligned read", d, 0);
        wrr(4'h0, 32'hFCF1_2345);
        rd(4'h0, d); check("R2 mode field mask", d, 32'h0001_2345);
        wrr(4'h0, 32'h0);
    endtask

    task automatic t_period;
        logic [31:0] d;
        int t0, t1, t2;
        wrr(4'h0, 32'h0100_0002);
        wait_flag(t0); rd(4'h8, d);
        wait_flag(t1); rd(4'h8, d);
        wait_flag(t2);
        check("R3 period v=2", t2 - t1, 48);
        rd(4'h8, d);
        repeat (104) @(negedge clk);
        rd(4'hC, d); check("R4 tally after two wraps", d[31:20], 2);
        rd(4'h4, d); check("R6 flag kept after image", d, 1);
        rd(4'hC, d); check("R6 tally kept after image", d[31:20], 2);
        rd(4'h8, d); check("R5 value returns old tally", d[31:20], 2);
        rd(4'hC, d); check("R5 tally cleared", d[31:20], 0);
        rd(4'h4, d); check("R5 flag cleared", d, 0);
        wrr(4'h0, 32'h0100_0005);
        wait_flag(t0); rd(4'h8, d);
        wait_flag(t1); rd(4'h8, d);
        wait_flag(t2);
        check("R3 period v=5", t2 - t1, 96);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        int t;
        rd(4'h8, d);
        wait_flag(t);
        @(negedge clk); check("R7 irq masked", {31'b0, irq}, 0);
        wrr(4'h0, 32'h0300_0005);
        @(negedge clk); check("R7 irq raised", {31'b0, irq}, 1);
        rd(4'h8, d);
        @(negedge clk); check("R7 irq dropped on ack", {31'b0, irq}, 0);
        wrr(4'h0, 32'h0100_0005);
    endtask

    task automatic t_ival;
        logic [31:0] d;
        logic [19:0] prev;
        int mx;
        wrr(4'h0, 32'h0100_0003);
        repeat (300) @(negedge clk);
        prev = 20'd1;
        for (int n = 0; n < 2000; n++) begin
            rd(4'hC, d);
            if (d[19:0] == 1 && prev != 1) break;
            prev = d[19:0];
        end
        wrr(4'h0, 32'h0100_0009);
        run_max(mx); check("R10 current period keeps old limit", mx, 3);
        run_max(mx); check("R10 next period uses new limit", mx, 9);
    endtask

    task automatic t_same;
        logic [31:0] d;
        logic [19:0] prev;
        wrr(4'h0, 32'h0100_0003);
        repeat (400) @(negedge clk);
        prev = 20'd3;
        for (int n = 0; n < 2000; n++) begin
            rd(4'hC, d);
            if (d[19:0] == 3 && prev != 3) break;
            prev = d[19:0];
        end
        repeat (14) @(negedge clk);
        rd(4'h8, d); check("R11 ack returns pre-wrap count", d[19:0], 3);
        rd(4'hC, d);
        check("R11 count wrapped", d[19:0], 0);
        check("R11 tally survives ack", d[31:20], 1);
        rd(4'h4, d); check("R11 flag survives ack", d, 1);
    endtask

    task automatic t_drain;
        logic [31:0] d;
        int mx;
        wrr(4'h0, 32'h0100_0007);
        repeat (300) @(negedge clk);
        for (int n = 0; n < 2000; n++) begin
            rd(4'hC, d);
            if (d[19:0] == 2) break;
        end
        rd(4'h8, d);
        wrr(4'h0, 32'h0000_0007);
        run_max(mx); check("R9 drain reaches limit", mx, 7);
        rd(4'h4, d); check("R9 final wrap sets flag", d, 1);
        repeat (100) @(negedge clk);
        rd(4'hC, d);
        check("R9 count holds zero", d[19:0], 0);
        check("R9 one final period", d[31:20], 1);
    endtask

    task automatic t_sat;
        logic [31:0] d;
        wrr(4'h0, 32'h0100_0000);
        repeat (66000) @(negedge clk);
        rd(4'hC, d); check("R8 tally saturates", d[31:20], 12'hFFF);
        rd(4'h8, d); check("R8 saturated value read", d[31:20], 12'hFFF);
        rd(4'hC, d); check("R8 ack leaves saturation", {31'b0, d[31:20] <= 1}, 1);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_period;
        t_irq;
        t_ival;
        t_same;
        t_drain;
        t_sat;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule